// File: doc/BRIEF.md
# CAN Mailbox Remote-Request Pending Flags

This block keeps three pending bitmaps for the 32 receive mailboxes of a CAN controller. When the receive path reports that a frame has been stored, it presents the mailbox number and whether the frame was a remote or a data frame. The block then sets the matching bits in three maps. The remote-request map is set only for remote frames, and only into mailboxes whose configuration accepts them. The data-receive map is set for data frames. The overwrite map is set when a new frame lands on a mailbox that still holds an unread one.

A CPU reads each map as two 16-bit words over a simple synchronous register bus, and clears bits by writing ones. Pending remote requests on mailboxes whose interrupt-mask bit is clear feed a summary flag. A global mask then gates that flag onto the interrupt line.

Top module: `can_rrq_flags`

## Requirements
- R1: After reset every bit of all three maps and the summary flag reads 0, and `rrq_irq` is low.
- R2: A stored remote frame sets remote-request bit `frm_mb` on the next clock edge only if `cfg_rmt_accept[frm_mb]` is 1; otherwise it changes no map. Address 0 returns mailboxes 15..0 (bit i = mailbox i) and address 1 returns mailboxes 31..16 (bit i = mailbox 16+i).
- R3: A stored data frame never newly sets a remote-request bit. It sets data-receive bit `frm_mb`, which reads at address 2 (mailboxes 15..0) and address 3 (mailboxes 31..16).
- R4: A register write clears every bit written as 1 in the addressed word on the next edge. Bits written as 0 keep their value. This applies to addresses 0 to 5 and to the summary flag at address 6 bit 0.
- R5: An accepted frame stored into a mailbox whose remote-request or data-receive bit is already set also sets that mailbox's overwrite bit, which reads at address 4 (15..0) and address 5 (31..16). When the earlier frame was of the other type, both pending bits of the mailbox end up set.
- R6: When a set and a write-1 clear hit the same bit in one cycle, the bit ends up set.
- R7: The summary flag (address 6 bit 0) becomes 1 on the same edge as a remote-request bit whose `cfg_irq_mask` bit is 0.
- R8: Writing 1 to the summary flag while an unmasked remote-request bit is pending makes it read 0 for one cycle, and it reads 1 again on the following cycle.
- R9: `rrq_irq` is 1 exactly when the summary flag is 1 and `glb_rrq_mask` is 0.
- R10: Reads have no side effects. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_stored | input | 1 | One-cycle strobe: a received frame was stored |
| frm_mb | input | 5 | Mailbox number of the stored frame |
| frm_is_remote | input | 1 | 1 = remote frame, 0 = data frame |
| cfg_rmt_accept | input | 32 | Per-mailbox: remote frames accepted |
| cfg_irq_mask | input | 32 | Per-mailbox: 1 keeps the mailbox out of the summary flag |
| glb_rrq_mask | input | 1 | 1 blocks the summary flag from the interrupt line |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Write strobe (write-one-to-clear) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed word, combinational |
| rrq_irq | output | 1 | Remote-request interrupt |

## Verification
A wrong bit in any map shows up in the read word of that map in the low phase right after the edge that should have changed it. The sweep reads every word after every store, so a bit set on the wrong mailbox, on a wrong frame type, or left set after a clear appears at most one stimulus later. A wrong summary state shows on `rrq_irq` in the same cycle unless the global mask hides it. The mask changes between stimuli, so a wrong summary state is seen within one sweep step.

// File: rtl/can_rrq_pkg.sv
package can_rrq_pkg;
  localparam int unsigned MAP_RRQ = 0;
  localparam int unsigned MAP_DRX = 1;
  localparam int unsigned MAP_OVW = 2;
  localparam int unsigned NUM_MAPS = 3;

  function automatic int unsigned word_addr(input int unsigned map_id,
                                            input int unsigned half,
                                            input int unsigned halves);
    return map_id * halves + half;
  endfunction
endpackage

// File: rtl/can_rrq_evt_dec.sv
module can_rrq_evt_dec #(
  parameter int unsigned NUM_MB = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              frm_stored,
  input  logic [IDX_W-1:0]  frm_mb,
  input  logic              frm_is_remote,
  input  logic [NUM_MB-1:0] cfg_rmt_accept,
  input  logic [NUM_MB-1:0] rrq_q,
  input  logic [NUM_MB-1:0] drx_q,
  output logic [NUM_MB-1:0] set_rrq,
  output logic [NUM_MB-1:0] set_drx,
  output logic [NUM_MB-1:0] set_ovw
);
  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    logic hit;
    logic take;
    logic unread;
    always_comb begin
      hit    = frm_stored && (frm_mb == IDX_W'(i));
      take   = hit && (!frm_is_remote || cfg_rmt_accept[i]);
      unread = rrq_q[i] || drx_q[i];
      set_rrq[i] = take && (frm_is_remote || rrq_q[i]);
      set_drx[i] = take && (!frm_is_remote || drx_q[i]);
      set_ovw[i] = take && unread;
    end
  end
endmodule

// File: rtl/can_rrq_pend_bank.sv
module can_rrq_pend_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] pend_q
);
  logic [WIDTH-1:0] pend_d;
  logic [WIDTH-1:0] pend_en;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      pend_en[b] = set_vec[b] || clr_vec[b];
      pend_d[b]  = set_vec[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[b] <= 1'b0;
      end else if (pend_en[b]) begin
        pend_q[b] <= pend_d[b];
      end
    end
  end
endmodule

// File: rtl/can_rrq_regif.sv
module can_rrq_regif
  import can_rrq_pkg::*;
#(
  parameter int unsigned NUM_MB = 32,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [NUM_MB-1:0] rrq_q,
  input  logic [NUM_MB-1:0] drx_q,
  input  logic [NUM_MB-1:0] ovw_q,
  input  logic              sum_q,
  output logic [NUM_MB-1:0] clr_rrq,
  output logic [NUM_MB-1:0] clr_drx,
  output logic [NUM_MB-1:0] clr_ovw,
  output logic              clr_sum,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam int unsigned HALVES   = NUM_MB / REG_W;
  localparam int unsigned N_WORDS  = NUM_MAPS * HALVES + 1;
  localparam int unsigned SUM_ADDR = NUM_MAPS * HALVES;

  logic [REG_W-1:0] rd_part [N_WORDS];

  for (genvar m = 0; m < NUM_MAPS; m++) begin : g_map
    for (genvar h = 0; h < HALVES; h++) begin : g_half
      localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(word_addr(m, h, HALVES));
      logic             sel;
      logic [REG_W-1:0] clr_w;
      logic [REG_W-1:0] cur_w;
      always_comb begin
        sel   = (reg_addr == WADDR);
        clr_w = (sel && reg_we) ? reg_wdata : '0;
      end
      if (m == MAP_RRQ) begin : g_rrq
        assign clr_rrq[h*REG_W +: REG_W] = clr_w;
        assign cur_w = rrq_q[h*REG_W +: REG_W];
      end else if (m == MAP_DRX) begin : g_drx
        assign clr_drx[h*REG_W +: REG_W] = clr_w;
        assign cur_w = drx_q[h*REG_W +: REG_W];
      end else begin : g_ovw
        assign clr_ovw[h*REG_W +: REG_W] = clr_w;
        assign cur_w = ovw_q[h*REG_W +: REG_W];
      end
      assign rd_part[m*HALVES + h] = sel ? cur_w : '0;
    end
  end

  logic sum_sel;
  always_comb begin
    sum_sel = (reg_addr == ADDR_W'(SUM_ADDR));
    clr_sum = sum_sel && reg_we && reg_wdata[0];
    rd_part[SUM_ADDR] = sum_sel ? {{(REG_W-1){1'b0}}, sum_q} : '0;
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      reg_rdata = reg_rdata | rd_part[w];
    end
  end
endmodule

// File: rtl/can_rrq_summary.sv
module can_rrq_summary #(
  parameter int unsigned NUM_MB = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_MB-1:0] set_rrq,
  input  logic [NUM_MB-1:0] rrq_q,
  input  logic [NUM_MB-1:0] cfg_irq_mask,
  input  logic              clr_sum,
  input  logic              glb_rrq_mask,
  output logic              sum_q,
  output logic              rrq_irq
);
  logic evt_unmasked;
  logic lvl_unmasked;
  logic sum_d;
  logic sum_en;

  always_comb begin
    evt_unmasked = |(set_rrq & ~cfg_irq_mask);
    lvl_unmasked = |(rrq_q & ~cfg_irq_mask);
    sum_d  = (sum_q && !clr_sum) || evt_unmasked || (lvl_unmasked && !clr_sum);
    sum_en = clr_sum || evt_unmasked || lvl_unmasked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= 1'b0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

  assign rrq_irq = sum_q && !glb_rrq_mask;
endmodule

// File: rtl/can_rrq_flags.sv
module can_rrq_flags
  import can_rrq_pkg::*;
#(
  parameter int unsigned NUM_MB = 32,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned IDX_W  = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_stored,
  input  logic [IDX_W-1:0]  frm_mb,
  input  logic              frm_is_remote,
  input  logic [NUM_MB-1:0] cfg_rmt_accept,
  input  logic [NUM_MB-1:0] cfg_irq_mask,
  input  logic              glb_rrq_mask,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              rrq_irq
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NUM_MB-1:0] rrq_map, drx_map, ovw_map;
  logic [NUM_MB-1:0] set_rrq, set_drx, set_ovw;
  logic [NUM_MB-1:0] clr_rrq, clr_drx, clr_ovw;
  logic              clr_sum;
  logic              sum_flag;

  can_rrq_evt_dec #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_dec (
    .frm_stored    (frm_stored),
    .frm_mb        (frm_mb),
    .frm_is_remote (frm_is_remote),
    .cfg_rmt_accept(cfg_rmt_accept),
    .rrq_q         (rrq_map),
    .drx_q         (drx_map),
    .set_rrq       (set_rrq),
    .set_drx       (set_drx),
    .set_ovw       (set_ovw)
  );

  can_rrq_pend_bank #(.WIDTH(NUM_MB)) u_rrq_bank (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(set_rrq), .clr_vec(clr_rrq), .pend_q(rrq_map)
  );
  can_rrq_pend_bank #(.WIDTH(NUM_MB)) u_drx_bank (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(set_drx), .clr_vec(clr_drx), .pend_q(drx_map)
  );
  can_rrq_pend_bank #(.WIDTH(NUM_MB)) u_ovw_bank (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(set_ovw), .clr_vec(clr_ovw), .pend_q(ovw_map)
  );

  can_rrq_regif #(.NUM_MB(NUM_MB), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regif (
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .rrq_q    (rrq_map),
    .drx_q    (drx_map),
    .ovw_q    (ovw_map),
    .sum_q    (sum_flag),
    .clr_rrq  (clr_rrq),
    .clr_drx  (clr_drx),
    .clr_ovw  (clr_ovw),
    .clr_sum  (clr_sum),
    .reg_rdata(reg_rdata)
  );

  can_rrq_summary #(.NUM_MB(NUM_MB)) u_sum (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .set_rrq     (set_rrq),
    .rrq_q       (rrq_map),
    .cfg_irq_mask(cfg_irq_mask),
    .clr_sum     (clr_sum),
    .glb_rrq_mask(glb_rrq_mask),
    .sum_q       (sum_flag),
    .rrq_irq     (rrq_irq)
  );
endmodule

// File: rtl/can_rrq_flags_chk.sv
module can_rrq_flags_chk #(
  parameter int unsigned NUM_MB = 32,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_stored,
  input logic [IDX_W-1:0]  frm_mb,
  input logic              frm_is_remote,
  input logic [NUM_MB-1:0] cfg_rmt_accept,
  input logic [NUM_MB-1:0] cfg_irq_mask,
  input logic              glb_rrq_mask,
  input logic              rrq_irq,
  input logic [NUM_MB-1:0] rrq_map,
  input logic [NUM_MB-1:0] drx_map,
  input logic [NUM_MB-1:0] ovw_map,
  input logic              sum_flag
);
  p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_stored && frm_is_remote && !cfg_rmt_accept[frm_mb] && !rrq_map[frm_mb])
    |=> !rrq_map[$past(frm_mb)]);

  p_data_no_rrq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_stored && !frm_is_remote && !rrq_map[frm_mb])
    |=> !rrq_map[$past(frm_mb)]);

  p_data_sets_drx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_stored && !frm_is_remote) |=> drx_map[$past(frm_mb)]);

  p_ovw_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_stored && (rrq_map[frm_mb] || drx_map[frm_mb])
     && (!frm_is_remote || cfg_rmt_accept[frm_mb]))
    |=> ovw_map[$past(frm_mb)]);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_stored && frm_is_remote && cfg_rmt_accept[frm_mb]) |=> rrq_map[$past(frm_mb)]);

  p_sum_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_stored && frm_is_remote && cfg_rmt_accept[frm_mb] && !cfg_irq_mask[frm_mb])
    |=> sum_flag);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rrq_irq |-> (sum_flag && !glb_rrq_mask));
endmodule

bind can_rrq_flags can_rrq_flags_chk #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .frm_stored    (frm_stored),
  .frm_mb        (frm_mb),
  .frm_is_remote (frm_is_remote),
  .cfg_rmt_accept(cfg_rmt_accept),
  .cfg_irq_mask  (cfg_irq_mask),
  .glb_rrq_mask  (glb_rrq_mask),
  .rrq_irq       (rrq_irq),
  .rrq_map       (rrq_map),
  .drx_map       (drx_map),
  .ovw_map       (ovw_map),
  .sum_flag      (sum_flag)
);

// File: tb/tb_can_rrq_flags.sv
module tb_can_rrq_flags;
  localparam int CLK_PERIOD = 10;
  localparam int NMB = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frm_stored;
  logic [4:0]  frm_mb;
  logic        frm_is_remote;
  logic [31:0] cfg_rmt_accept;
  logic [31:0] cfg_irq_mask;
  logic        glb_rrq_mask;
  logic [2:0]  reg_addr;
  logic        reg_we;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        rrq_irq;

  int n_chk = 0;
  int n_bad = 0;

  // bench-side expected state
  logic [31:0] m_rrq, m_drx, m_ovw;
  logic        m_sum;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rrq_flags dut (
    .clk(clk), .rst_n(rst_n), .frm_stored(frm_stored), .frm_mb(frm_mb),
    .frm_is_remote(frm_is_remote), .cfg_rmt_accept(cfg_rmt_accept),
    .cfg_irq_mask(cfg_irq_mask), .glb_rrq_mask(glb_rrq_mask),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rrq_irq(rrq_irq)
  );

  // Expected state from the requirements, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rrq = '0; m_drx = '0; m_ovw = '0; m_sum = 1'b0;
    end else begin
      logic [31:0] c_rrq, c_drx, c_ovw, s_rrq, s_drx, s_ovw;
      logic        c_sum, accepted, busy;
      c_rrq = '0; c_drx = '0; c_ovw = '0; c_sum = 1'b0;
      s_rrq = '0; s_drx = '0; s_ovw = '0;
      if (reg_we) begin
        case (reg_addr)
          3'd0: c_rrq[15:0]  = reg_wdata;
          3'd1: c_rrq[31:16] = reg_wdata;
          3'd2: c_drx[15:0]  = reg_wdata;
          3'd3: c_drx[31:16] = reg_wdata;
          3'd4: c_ovw[15:0]  = reg_wdata;
          3'd5: c_ovw[31:16] = reg_wdata;
          3'd6: c_sum = reg_wdata[0];
          default: ;
        endcase
      end
      if (frm_stored) begin
        accepted = !frm_is_remote || cfg_rmt_accept[frm_mb];
        busy = m_rrq[frm_mb] || m_drx[frm_mb];
        if (accepted) begin
          if (frm_is_remote) s_rrq[frm_mb] = 1'b1; else s_drx[frm_mb] = 1'b1;
          if (busy) begin
            s_ovw[frm_mb] = 1'b1;
            if (m_rrq[frm_mb]) s_rrq[frm_mb] = 1'b1;
            if (m_drx[frm_mb]) s_drx[frm_mb] = 1'b1;
          end
        end
      end
      m_sum = (m_sum && !c_sum) || ((s_rrq & ~cfg_irq_mask) != 0)
              || (((m_rrq & ~cfg_irq_mask) != 0) && !c_sum);
      m_rrq = (m_rrq & ~c_rrq) | s_rrq;
      m_drx = (m_drx & ~c_drx) | s_drx;
      m_ovw = (m_ovw & ~c_ovw) | s_ovw;
    end
  end

  function automatic logic [15:0] exp_word(input logic [2:0] a);
    case (a)
      3'd0: return m_rrq[15:0];
      3'd1: return m_rrq[31:16];
      3'd2: return m_drx[15:0];
      3'd3: return m_drx[31:16];
      3'd4: return m_ovw[15:0];
      3'd5: return m_ovw[31:16];
      3'd6: return {15'd0, m_sum};
      default: return 16'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4, 3'd5: return "R5";
      3'd6: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic cmp16(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Read one word in the low phase and compare, plus the interrupt line (R9)
  task automatic check_addr(input logic [2:0] a, input string req);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    #1;
    cmp16($sformatf("%s/%s addr %0d", req, tag_of(a), a), reg_rdata, exp_word(a));
    cmp16("R9 irq", {15'd0, rrq_irq}, {15'd0, m_sum && !glb_rrq_mask});
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 8; a++) check_addr(3'(a), req);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_store(input int mb, input logic rmt);
    @(negedge clk);
    frm_stored = 1'b1; frm_mb = 5'(mb); frm_is_remote = rmt;
    @(negedge clk);
    frm_stored = 1'b0;
  endtask

  task automatic clear_all();
    for (int a = 0; a < 7; a++) do_write(3'(a), 16'hFFFF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frm_stored = 1'b0; frm_mb = '0; frm_is_remote = 1'b0;
    cfg_rmt_accept = '0; cfg_irq_mask = '0; glb_rrq_mask = 1'b0;
    reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, all words zero and no interrupt
    for (int a = 0; a < 8; a++) begin
      check_addr(3'(a), "R1");
      cmp16("R1 word", reg_rdata, 16'h0000);
    end

    // Sweep: every mailbox, frame type, acceptance and pre-state
    for (int mb = 0; mb < NMB; mb++) begin
      for (int t = 0; t < 8; t++) begin
        clear_all();
        cfg_irq_mask   = (32'h5555_5555 << t) ^ (32'(mb) * 32'h0101_0101);
        glb_rrq_mask   = mb[0] ^ t[0];
        if (t[2]) begin
          cfg_rmt_accept = '1;
          do_store(mb, !t[0]);
        end
        cfg_rmt_accept = t[1] ? ~(32'h1 << ((mb + 7) % NMB)) : (32'h1 << ((mb + 7) % NMB));
        do_store(mb, t[0]);
        check_all("R2 R3 R5 sweep");
      end
    end

    // R4: writing zeros changes nothing; ones clear only the written bits
    clear_all();
    cfg_rmt_accept = '1; cfg_irq_mask = '0; glb_rrq_mask = 1'b0;
    do_store(3, 1'b1); do_store(20, 1'b0); do_store(20, 1'b1);
    for (int a = 0; a < 7; a++) do_write(3'(a), 16'h0000);
    check_all("R4 write-zero");
    do_write(3'd2, 16'h0001);
    check_all("R4 partial clear");

    // R6: set and clear of the same bit in one cycle, bit stays set
    @(negedge clk);
    frm_stored = 1'b1; frm_mb = 5'd5; frm_is_remote = 1'b1;
    reg_addr = 3'd0; reg_we = 1'b1; reg_wdata = 16'hFFFF;
    @(negedge clk);
    frm_stored = 1'b0; reg_we = 1'b0;
    #1;
    cmp16("R6 set beats clear", reg_rdata & 16'h0020, 16'h0020);
    check_all("R6");

    // R8: summary clear while an unmasked request is pending
    @(negedge clk);
    reg_addr = 3'd6; reg_we = 1'b1; reg_wdata = 16'h0001;
    @(negedge clk);
    reg_we = 1'b0;
    #1;
    cmp16("R8 summary dropped", reg_rdata, 16'h0000);
    cmp16("R8 model", reg_rdata, exp_word(3'd6));
    @(negedge clk);
    #1;
    cmp16("R8 summary back", reg_rdata, 16'h0001);

    // R9: global mask gates the line
    glb_rrq_mask = 1'b1;
    check_addr(3'd6, "R9 masked");
    glb_rrq_mask = 1'b0;
    check_addr(3'd6, "R9 unmasked");

    // R7 / R9: all pending requests masked, summary cleared stays clear
    cfg_irq_mask = '1;
    do_write(3'd6, 16'h0001);
    check_all("R7 masked");
    do_store(9, 1'b1);
    check_all("R7 masked event");

    // R10: repeated reads leave everything unchanged, address 7 reads 0
    for (int k = 0; k < 3; k++) check_all("R10 reread");
    check_addr(3'd7, "R10 unmapped");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule